// File: doc/BRIEF.md
# Interrupt-Serviced Descriptor Transfer Engine

This block handles a peripheral interrupt in hardware. Each service moves one data item between an I/O register address and a memory buffer address, so no software handler has to run. The transfer follows a descriptor made of four registers:

- an 8-bit control register;
- a 24-bit buffer pointer;
- a 16-bit I/O pointer;
- a 16-bit transfer counter.

Software loads these registers through a small write port while the engine is idle. The peripheral then pulses a request. For each request the engine makes one read and one write on a synchronous memory-bus master port. It then advances the pointers that are enabled for update and decrements the counter.

When the counter reaches zero, the engine raises a done pulse, and the system then takes an ordinary interrupt. A peripheral can also end the sequence early by sending an end request together with its service request, if the control register allows it.

The buffer pointer covers a 16 MB space. Its updates touch only the low 16 bits, so the upper byte acts as a fixed bank that never receives a carry.

Top module: `irq_xfer_engine`

## Requirements
- R1: After reset, the control register and the counter read 0. `busy` is low and `mem_valid` is low.
- R2: Descriptor writes take effect only while `busy` is low and no request is pending. Writes made at any other time are ignored.
  - The write selector picks the register: 0 = control, 1 = buffer pointer, 2 = I/O pointer, 3 = counter.
  - Control bits [7:5] are reserved and always read as 0.
- R3: Control bit 1 selects the direction. Each service issues its read first and its write second, on the same bus port.
  - Bit 1 = 0: read from the I/O pointer (zero-extended to 24 bits), then write to the buffer pointer.
  - Bit 1 = 1: read from the buffer pointer, then write to the I/O pointer.
- R4: Control bit 0 selects the data size, and `mem_word` follows it.
  - Bit 0 = 1 (word): all 16 data bits are moved.
  - Bit 0 = 0 (byte): only `mem_rdata[7:0]` is moved, and `mem_wdata[15:8]` is 0.
- R5: When control bit 2 = 0, each completed service adds the step (1 for a byte, 2 for a word) to `buf_ptr[15:0]` only. `buf_ptr[23:16]` never changes, so 0xFFFF wraps to 0 within the bank. When bit 2 = 1, the buffer pointer stays fixed.
- R6: When control bit 3 = 0, each completed service adds the same step to the I/O pointer. When bit 3 = 1, the I/O pointer stays fixed.
- R7: Each completed service pulses `svc_ack` for one cycle and decrements the counter by 1. `done` pulses together with `svc_ack` when the decremented value is 0.
- R8: Termination: control bit 4 = 1 and a request arrives with `svc_end` high.
  - The service makes no bus access and leaves the descriptor unchanged.
  - It pulses `svc_ack`, `done` and `done_term` together.
- R9: When control bit 4 = 0, `svc_end` has no effect and the service runs normally.
- R10: A request that arrives while a service is in progress is held. It is served after the current read/write pair and the descriptor update have finished.
- R11: A request that arrives while the counter is 0 and no termination applies is discarded. It produces no bus access and no acknowledge.
- R12: While `mem_valid` is high and `mem_ready` is low, `mem_valid`, `mem_addr` and `mem_we` stay unchanged. Each service makes exactly one read beat and one write beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Descriptor write strobe |
| cfg_sel | input | 2 | Register selector: 0 control, 1 buffer pointer, 2 I/O pointer, 3 counter |
| cfg_wdata | input | 24 | Descriptor write data |
| svc_req | input | 1 | Service request pulse from the peripheral |
| svc_end | input | 1 | End request, sampled together with `svc_req` |
| svc_ack | output | 1 | One-cycle pulse when a service finishes |
| done | output | 1 | Sequence complete (count reached 0 or terminated) |
| done_term | output | 1 | Completion caused by a peripheral end request |
| busy | output | 1 | A service is in progress |
| mem_valid | output | 1 | Bus request valid |
| mem_we | output | 1 | Bus write (1) or read (0) |
| mem_word | output | 1 | Bus size: word (1) or byte (0) |
| mem_addr | output | 24 | Bus address |
| mem_wdata | output | 16 | Bus write data |
| mem_ready | input | 1 | Bus beat accepted |
| mem_rdata | input | 16 | Bus read data |
| ctrl | output | 8 | Control register value |
| buf_ptr | output | 24 | Buffer pointer value |
| io_ptr | output | 16 | I/O pointer value |
| xfer_cnt | output | 16 | Transfer counter value |

## Verification
Each service runs against a bus model whose read data is computed from the address. A wrong source or destination, and a lost or extra data byte, therefore both show up in the written data.

Directed cases set up specific combinations of settings:

- Buffer addresses sit just below a bank boundary in both sizes, which shows whether a carry leaks into the bank byte.
- Both pointers frozen, which separates fixed updates from incrementing ones.
- End requests sent with termination enabled and with it disabled.
- A second request issued during a transfer, which shows whether requests are queued or dropped.
- A request made with a zero counter.

Randomized descriptors with random ready stalls then mix every combination of direction, size and freeze settings. This tells a correct step size and direction apart from one that is only right for the patterns chosen by hand.

// File: rtl/irq_xfer_engine.sv
module irq_xfer_engine #(
  parameter int ADDR_W = 24,
  parameter int OFS_W  = 16,
  parameter int IO_W   = 16,
  parameter int DATA_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [ADDR_W-1:0] cfg_wdata,
  input  logic              svc_req,
  input  logic              svc_end,
  output logic              svc_ack,
  output logic              done,
  output logic              done_term,
  output logic              busy,
  output logic              mem_valid,
  output logic              mem_we,
  output logic              mem_word,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ready,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [7:0]        ctrl,
  output logic [ADDR_W-1:0] buf_ptr,
  output logic [IO_W-1:0]   io_ptr,
  output logic [CNT_W-1:0]  xfer_cnt
);

  typedef enum logic [2:0] {S_IDLE, S_RD, S_WR, S_UPD, S_FIN} st_t;
  st_t st;

  logic              pend, pend_end;
  logic [DATA_W-1:0] dbuf;

  wire f_word  = ctrl[0];
  wire f_dir   = ctrl[1];
  wire f_bhold = ctrl[2];
  wire f_ihold = ctrl[3];
  wire f_term  = ctrl[4];

  wire [OFS_W-1:0] bstep = {{(OFS_W-2){1'b0}}, f_word, ~f_word};
  wire [IO_W-1:0]  istep = {{(IO_W-2){1'b0}}, f_word, ~f_word};

  wire [ADDR_W-1:0] io_addr = {{(ADDR_W-IO_W){1'b0}}, io_ptr};
  wire [ADDR_W-1:0] src     = f_dir ? buf_ptr : io_addr;
  wire [ADDR_W-1:0] dst     = f_dir ? io_addr : buf_ptr;
  wire [CNT_W-1:0]  cnt_m1  = xfer_cnt - 1'b1;

  wire take   = (st == S_IDLE) && pend;
  wire cfg_ok = (st == S_IDLE) && !pend && cfg_we;

  assign busy      = (st != S_IDLE);
  assign mem_valid = (st == S_RD) || (st == S_WR);
  assign mem_we    = (st == S_WR);
  assign mem_word  = f_word;
  assign mem_addr  = (st == S_WR) ? dst : src;
  assign mem_wdata = dbuf;
  assign svc_ack   = (st == S_UPD) || (st == S_FIN);
  assign done_term = (st == S_FIN);
  assign done      = ((st == S_UPD) && (cnt_m1 == '0)) || (st == S_FIN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      pend     <= 1'b0;
      pend_end <= 1'b0;
      ctrl     <= '0;
      buf_ptr  <= '0;
      io_ptr   <= '0;
      xfer_cnt <= '0;
      dbuf     <= '0;
    end else begin
      pend     <= svc_req | (pend & ~take);
      pend_end <= (svc_req & svc_end) | (pend_end & ~take);

      if (cfg_ok) begin
        case (cfg_sel)
          2'd0:    ctrl     <= {3'b000, cfg_wdata[4:0]};
          2'd1:    buf_ptr  <= cfg_wdata;
          2'd2:    io_ptr   <= cfg_wdata[IO_W-1:0];
          default: xfer_cnt <= cfg_wdata[CNT_W-1:0];
        endcase
      end

      case (st)
        S_IDLE: if (take) begin
          if (pend_end && f_term)  st <= S_FIN;
          else if (xfer_cnt != '0) st <= S_RD;
        end
        S_RD: if (mem_ready) begin
          dbuf <= f_word ? mem_rdata : {{(DATA_W-8){1'b0}}, mem_rdata[7:0]};
          st   <= S_WR;
        end
        S_WR: if (mem_ready) st <= S_UPD;
        S_UPD: begin
          if (!f_bhold) buf_ptr[OFS_W-1:0] <= buf_ptr[OFS_W-1:0] + bstep;
          if (!f_ihold) io_ptr <= io_ptr + istep;
          xfer_cnt <= cnt_m1;
          st       <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/irq_xfer_engine_chk.sv
module irq_xfer_engine_chk #(
  parameter int ADDR_W = 24,
  parameter int OFS_W  = 16,
  parameter int IO_W   = 16,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_we,
  input logic              svc_ack,
  input logic              done,
  input logic              done_term,
  input logic              busy,
  input logic              mem_valid,
  input logic              mem_we,
  input logic              mem_ready,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [7:0]        ctrl,
  input logic [ADDR_W-1:0] buf_ptr,
  input logic [IO_W-1:0]   io_ptr,
  input logic [CNT_W-1:0]  xfer_cnt
);

  p_cfg_locked_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(ctrl));

  p_read_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_valid) |-> !mem_we);

  p_bank_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cfg_we) |-> $stable(buf_ptr[ADDR_W-1:OFS_W]));

  p_io_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (svc_ack && !done_term) |=> ((io_ptr - $past(io_ptr)) <= IO_W'(2)));

  p_count_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (svc_ack && !done_term) |=> (xfer_cnt == $past(xfer_cnt) - 1'b1));

  p_term_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_term |-> (done && svc_ack && !mem_valid));

  p_bus_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_we)));

endmodule

bind irq_xfer_engine irq_xfer_engine_chk #(
  .ADDR_W(ADDR_W), .OFS_W(OFS_W), .IO_W(IO_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .svc_ack(svc_ack), .done(done),
  .done_term(done_term), .busy(busy), .mem_valid(mem_valid), .mem_we(mem_we),
  .mem_ready(mem_ready), .mem_addr(mem_addr), .ctrl(ctrl), .buf_ptr(buf_ptr),
  .io_ptr(io_ptr), .xfer_cnt(xfer_cnt)
);

// File: tb/irq_xfer_engine_tb.sv
module irq_xfer_engine_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = 2'd0;
  logic [23:0] cfg_wdata = '0;
  logic        svc_req = 1'b0, svc_end = 1'b0;
  logic        svc_ack, done, done_term, busy;
  logic        mem_valid, mem_we, mem_word, mem_ready;
  logic [23:0] mem_addr;
  logic [15:0] mem_wdata, mem_rdata;
  logic [7:0]  ctrl;
  logic [23:0] buf_ptr;
  logic [15:0] io_ptr, xfer_cnt;

  always #10 clk = ~clk;

  irq_xfer_engine u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .svc_req(svc_req), .svc_end(svc_end), .svc_ack(svc_ack), .done(done),
    .done_term(done_term), .busy(busy), .mem_valid(mem_valid), .mem_we(mem_we),
    .mem_word(mem_word), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ready(mem_ready), .mem_rdata(mem_rdata), .ctrl(ctrl), .buf_ptr(buf_ptr),
    .io_ptr(io_ptr), .xfer_cnt(xfer_cnt)
  );

  int vectors = 0, fails = 0;
  int rdy_mode = 1;

  function automatic logic [15:0] mval(input logic [23:0] a);
    return a[15:0] ^ {a[23:16], 8'h5A} ^ 16'h9371;
  endfunction
  assign mem_rdata = mval(mem_addr);

  initial begin
    void'($urandom(32'd4051));
    mem_ready = 1'b0;
    forever begin
      @(posedge clk); #3;
      case (rdy_mode)
        0: mem_ready = (($urandom % 3) != 0);
        1: mem_ready = 1'b1;
        default: mem_ready = 1'b0;
      endcase
    end
  end

  logic        lg_we[8], lg_word[8];
  logic [23:0] lg_addr[8];
  logic [15:0] lg_wdata[8];
  int          lg_n = 0;
  initial forever begin
    @(negedge clk);
    if (mem_valid && mem_ready && lg_n < 8) begin
      lg_we[lg_n] = mem_we; lg_word[lg_n] = mem_word;
      lg_addr[lg_n] = mem_addr; lg_wdata[lg_n] = mem_wdata;
      lg_n++;
    end
  end

  logic [7:0]  m_ctrl;
  logic [23:0] m_buf;
  logic [15:0] m_io, m_cnt;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cfg(input logic [1:0] sel, input logic [23:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic load(input logic [7:0] c, input logic [23:0] b, input logic [15:0] io, input logic [15:0] n);
    cfg(2'd0, {16'h0, c}); cfg(2'd1, b); cfg(2'd2, {8'h0, io}); cfg(2'd3, {8'h0, n});
    m_ctrl = c & 8'h1F; m_buf = b; m_io = io; m_cnt = n;
  endtask

  task automatic pulse(input bit e);
    @(negedge clk); svc_req = 1'b1; svc_end = e;
    @(negedge clk); svc_req = 1'b0; svc_end = 1'b0;
  endtask

  task automatic run(input int nreq, input bit endf);
    logic        e_we[8], e_word[8];
    logic [23:0] e_addr[8];
    logic [15:0] e_wdata[8];
    int e_n = 0, acks = 0, tmo = 0;
    bit first_term;
    logic [23:0] s, d;
    logic [15:0] v;
    first_term = endf && m_ctrl[4];
    lg_n = 0;
    pulse(endf);
    if (nreq == 2) pulse(1'b0);
    while (acks < nreq && tmo < 400) begin
      if (svc_ack) begin
        if (acks == 0 && first_term) begin
          chk(done && done_term, "R8 terminate pulses", {30'b0, done, done_term}, 32'h3);
        end else begin
          chk(done == (m_cnt == 16'd1) && !done_term, "R7 done at zero",
              {31'b0, done}, {31'b0, m_cnt == 16'd1});
          s = m_ctrl[1] ? m_buf : {8'h0, m_io};
          d = m_ctrl[1] ? {8'h0, m_io} : m_buf;
          v = m_ctrl[0] ? mval(s) : {8'h0, mval(s)[7:0]};
          e_we[e_n] = 0; e_word[e_n] = m_ctrl[0]; e_addr[e_n] = s; e_wdata[e_n] = 'x; e_n++;
          e_we[e_n] = 1; e_word[e_n] = m_ctrl[0]; e_addr[e_n] = d; e_wdata[e_n] = v; e_n++;
          if (!m_ctrl[2]) m_buf[15:0] = m_buf[15:0] + (m_ctrl[0] ? 16'd2 : 16'd1);
          if (!m_ctrl[3]) m_io = m_io + (m_ctrl[0] ? 16'd2 : 16'd1);
          m_cnt = m_cnt - 16'd1;
        end
        acks++;
      end
      if (acks < nreq) begin @(negedge clk); tmo++; end
    end
    chk(acks == nreq, "R10 acknowledge count", acks, nreq);
    @(negedge clk);
    chk(lg_n == e_n, "R12 beat count", lg_n, e_n);
    for (int i = 0; i < e_n && i < lg_n; i++) begin
      chk(lg_we[i] == e_we[i] && lg_addr[i] == e_addr[i], "R3 beat order/address",
          {7'b0, lg_we[i], lg_addr[i]}, {7'b0, e_we[i], e_addr[i]});
      chk(lg_word[i] == e_word[i], "R4 beat size", lg_word[i], e_word[i]);
      if (e_we[i]) chk(lg_wdata[i] == e_wdata[i], "R4 write data", lg_wdata[i], e_wdata[i]);
    end
    chk(buf_ptr == m_buf, "R5 buffer pointer", buf_ptr, m_buf);
    chk(io_ptr == m_io, "R6 I/O pointer", io_ptr, m_io);
    chk(xfer_cnt == m_cnt, "R7 counter", xfer_cnt, m_cnt);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    int seen;
    void'($urandom(32'd9137));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(ctrl == 8'h00 && xfer_cnt == 16'h0, "R1 reset registers", {ctrl, xfer_cnt}, 0);
    chk(!busy && !mem_valid, "R1 reset idle", {busy, mem_valid}, 0);

    // R2 reserved bits read 0
    cfg(2'd0, 24'h0000FF);
    chk(ctrl == 8'h1F, "R2 reserved bits", ctrl, 8'h1F);

    // word, I/O to buffer, bank boundary (R3 R4 R5 R6)
    load(8'h01, 24'h12FFFF, 16'h0040, 16'd2);
    run(1, 0);
    chk(buf_ptr[23:16] == 8'h12, "R5 bank unchanged on wrap", buf_ptr, 24'h120001);
    // byte, buffer to I/O, last item (R7)
    load(8'h02, 24'h34FFFF, 16'h1000, 16'd1);
    run(1, 0);
    // both pointers frozen
    load(8'h0D, 24'h00ABCD, 16'h2222, 16'd3);
    run(1, 0);
    // R8 termination
    load(8'h10, 24'h050000, 16'h0300, 16'd3);
    run(1, 1);
    // R9 end request ignored
    load(8'h00, 24'h060010, 16'h0310, 16'd3);
    run(1, 1);
    // R10 pending request
    load(8'h03, 24'h07FFFE, 16'h0400, 16'd4);
    run(2, 0);

    // R11 zero counter discards request
    load(8'h01, 24'h080000, 16'h0500, 16'd0);
    lg_n = 0; seen = 0;
    pulse(1'b0);
    repeat (10) begin @(negedge clk); if (svc_ack) seen++; end
    chk(seen == 0 && lg_n == 0, "R11 zero-count request", {seen[15:0], lg_n[15:0]}, 0);

    // R2 writes during a service are ignored
    load(8'h01, 24'h090000, 16'h0600, 16'd5);
    rdy_mode = 2;
    pulse(1'b0);
    @(negedge clk);
    cfg(2'd0, 24'h00000E);
    cfg(2'd3, 24'h000077);
    rdy_mode = 1;
    seen = 0;
    while (!busy == 0 && seen < 50) begin @(negedge clk); seen++; end
    @(negedge clk);
    chk(ctrl == 8'h01, "R2 control locked while busy", ctrl, 8'h01);
    chk(xfer_cnt == 16'd4, "R2 counter locked while busy", xfer_cnt, 16'd4);

    // randomized services with bus stalls (R3 R4 R5 R6 R12)
    rdy_mode = 0;
    for (int k = 0; k < 60; k++) begin
      load(8'($urandom % 16), 24'($urandom), 16'($urandom), 16'(1 + $urandom % 3));
      run(1, 0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule